// File: doc/BRIEF.md
# Pointer Bounds Check Unit

This block stores a small set of pointer bounds pairs and checks effective addresses against them. Each pair holds an inclusive lower limit and an exclusive upper limit, so the upper value is the first address outside the permitted region. A requester presents one operation per cycle with a valid strobe. The operation names a register by index and either loads a new pair into that register or checks an address against it.

There are three check kinds. The lower check always raises a fault pulse when it fails. The exceptional upper check also raises a fault pulse when it fails. The non-exceptional upper check never raises a fault and only records the violation in a readable status register. Every failed check, of any kind, writes a failure code and the offending address into that status register. A global enable input gates all of this. With the enable low, every operation produces an undefined-operation pulse instead and changes no state.

Top module: `ptr_bounds_unit`

## Requirements
- R1: After reset every register holds lower = 0 and upper = all ones, so every address below all ones passes every check, and the all-ones address fails an upper check. The status register reads code 0 and address 0.
- R2: Opcode 0 (load bounds) with the enable high writes `addr_i` as the lower limit and `limit_i` as the upper limit of register `idx_i`. No other register changes.
- R3: Opcode 1 (lower check) fails when `addr_i` is strictly below the lower limit. An address equal to the lower limit passes. A failure always raises a fault.
- R4: Opcode 2 (exceptional upper check) fails and raises a fault when `addr_i` is greater than or equal to the upper limit.
- R5: Opcode 3 (non-exceptional upper check) uses the same condition as R4, but it never raises a fault.
- R6: Any failed check sets `status_code_o` to 1 and `status_addr_o` to the offending address. A passing check or a bounds load leaves both unchanged.
- R7: With `en_i` low, any valid operation raises `ud_o`. It raises no fault and changes neither the bounds nor the status.
- R8: `fault_o` and `ud_o` are high for exactly the cycle after the cycle in which the valid strobe is sampled. They are never high without a request in the previous cycle, and never high together.
- R9: During a fault, `fault_code_o[1]` is 1 and `fault_code_o[0]` gives the side of the violation: 1 for a lower violation, 0 for an upper violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Global enable for all operations |
| vld_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 load, 1 lower check, 2 upper check with fault, 3 upper check without fault |
| idx_i | input | 2 | Register index |
| addr_i | input | 64 | Address to check, or lower limit when loading |
| limit_i | input | 64 | Upper limit when loading |
| fault_o | output | 1 | Fault pulse |
| fault_code_o | output | 2 | Fault code (bit 1 set on a fault, bit 0 gives the side) |
| ud_o | output | 1 | Undefined-operation pulse |
| status_code_o | output | 2 | Last failure code (0 none, 1 check failure) |
| status_addr_o | output | 64 | Address of the last failed check |

## Verification
The bench builds the unit with its default parameters: four registers and 64-bit addresses. At that width the extreme corners are reachable. These include the all-ones address against the reset upper limit, and addresses one below and exactly at each programmed limit. Every one of the four indices is loaded and read back through checks, so a write that reaches the wrong register shows up as a wrong pass or fail. Sequences of back-to-back failures, disabled operations placed between enabled ones, and non-faulting violations test whether the status register holds or updates at each step.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [1:0] {
    OP_SETB  = 2'd0,
    OP_CKLO  = 2'd1,
    OP_CKUP  = 2'd2,
    OP_CKUPN = 2'd3
  } pbc_op_e;

  localparam int STAT_W = 2;
  localparam logic [STAT_W-1:0] STAT_NONE    = 2'd0;
  localparam logic [STAT_W-1:0] STAT_CHKFAIL = 2'd1;
endpackage

// File: rtl/pbc_bank.sv
module pbc_bank #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 64,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_lo,
  input  logic [ADDR_W-1:0] wr_hi,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_lo,
  output logic [ADDR_W-1:0] rd_hi
);
  logic [ADDR_W-1:0] lo_q [NUM_REGS];
  logic [ADDR_W-1:0] hi_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '1;
      end else if (hit) begin
        lo_q[g] <= wr_lo;
        hi_q[g] <= wr_hi;
      end
    end
  end

  assign rd_lo = lo_q[rd_idx];
  assign rd_hi = hi_q[rd_idx];
endmodule

// File: rtl/pbc_cmp.sv
module pbc_cmp #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              lo_fail,
  output logic              up_fail
);
  function automatic logic under_floor(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] f);
    return a < f;
  endfunction

  function automatic logic past_ceiling(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] c);
    return !(a < c);
  endfunction

  assign lo_fail = under_floor(addr, lo);
  assign up_fail = past_ceiling(addr, hi);
endmodule

// File: rtl/pbc_resp.sv
module pbc_resp
  import pbc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ud_in,
  input  logic              fault_in,
  input  logic              fault_lo_in,
  input  logic              stat_wr_in,
  input  logic [ADDR_W-1:0] stat_addr_in,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic              ud_o,
  output logic [STAT_W-1:0] status_code_o,
  output logic [ADDR_W-1:0] status_addr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_o       <= 1'b0;
      fault_code_o  <= 2'b00;
      ud_o          <= 1'b0;
      status_code_o <= STAT_NONE;
      status_addr_o <= '0;
    end else begin
      fault_o      <= fault_in;
      fault_code_o <= fault_in ? {1'b1, fault_lo_in} : 2'b00;
      ud_o         <= ud_in;
      if (stat_wr_in) begin
        status_code_o <= STAT_CHKFAIL;
        status_addr_o <= stat_addr_in;
      end
    end
  end
endmodule

// File: rtl/ptr_bounds_unit.sv
module ptr_bounds_unit
  import pbc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 64,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [1:0]        op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic              ud_o,
  output logic [STAT_W-1:0] status_code_o,
  output logic [ADDR_W-1:0] status_addr_o
);
  pbc_op_e op;
  assign op = pbc_op_e'(op_i);

  logic              act_w;
  logic              wr_w;
  logic              ud_w;
  logic              lo_fail_w, up_fail_w;
  logic              chk_lo_viol_w, chk_up_viol_w;
  logic              fault_w, stat_wr_w;
  logic [ADDR_W-1:0] sel_lo_w, sel_hi_w;

  assign act_w = vld_i && en_i;
  assign ud_w  = vld_i && !en_i;
  assign wr_w  = act_w && (op == OP_SETB);

  pbc_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_w),
    .wr_idx (idx_i),
    .wr_lo  (addr_i),
    .wr_hi  (limit_i),
    .rd_idx (idx_i),
    .rd_lo  (sel_lo_w),
    .rd_hi  (sel_hi_w)
  );

  pbc_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr    (addr_i),
    .lo      (sel_lo_w),
    .hi      (sel_hi_w),
    .lo_fail (lo_fail_w),
    .up_fail (up_fail_w)
  );

  assign chk_lo_viol_w = act_w && (op == OP_CKLO) && lo_fail_w;
  assign chk_up_viol_w = act_w && ((op == OP_CKUP) || (op == OP_CKUPN)) && up_fail_w;
  assign fault_w       = chk_lo_viol_w || (chk_up_viol_w && (op == OP_CKUP));
  assign stat_wr_w     = chk_lo_viol_w || chk_up_viol_w;

  pbc_resp #(.ADDR_W(ADDR_W)) u_resp (
    .clk           (clk),
    .rst_n         (rst_n),
    .ud_in         (ud_w),
    .fault_in      (fault_w),
    .fault_lo_in   (chk_lo_viol_w),
    .stat_wr_in    (stat_wr_w),
    .stat_addr_in  (addr_i),
    .fault_o       (fault_o),
    .fault_code_o  (fault_code_o),
    .ud_o          (ud_o),
    .status_code_o (status_code_o),
    .status_addr_o (status_addr_o)
  );
endmodule

// File: rtl/pbc_sva.sv
module pbc_sva #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              vld_i,
  input logic [1:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              fault_o,
  input logic [1:0]        fault_code_o,
  input logic              ud_o,
  input logic [1:0]        status_code_o,
  input logic [ADDR_W-1:0] status_addr_o,
  input logic              stat_wr_w
);
  AST_UD_NEEDS_DISABLED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ud_o |-> $past(vld_i && !en_i)); // R7

  AST_DISABLED_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vld_i && !en_i) |-> (status_code_o == $past(status_code_o)) &&
                              (status_addr_o == $past(status_addr_o)) && !fault_o); // R7

  AST_SOFT_CHECK_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vld_i && en_i && op_i == 2'd3) |-> !fault_o); // R5

  AST_FAULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(vld_i && en_i && (op_i == 2'd1 || op_i == 2'd2))); // R8

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_o && ud_o)); // R8

  AST_LOWER_CODE_FROM_LOWER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> fault_code_o[1] && (fault_code_o[0] == $past(op_i == 2'd1))); // R9

  AST_FAULT_RECORDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (status_code_o == 2'd1) && (status_addr_o == $past(addr_i))); // R6

  AST_STATUS_HOLDS_UNLESS_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_w |=> $stable(status_code_o) && $stable(status_addr_o)); // R6
endmodule

bind ptr_bounds_unit pbc_sva #(.ADDR_W(ADDR_W)) u_pbc_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_i          (en_i),
  .vld_i         (vld_i),
  .op_i          (op_i),
  .addr_i        (addr_i),
  .fault_o       (fault_o),
  .fault_code_o  (fault_code_o),
  .ud_o          (ud_o),
  .status_code_o (status_code_o),
  .status_addr_o (status_addr_o),
  .stat_wr_w     (stat_wr_w)
);

// File: tb/tb_ptr_bounds_unit.sv
module tb_ptr_bounds_unit;
  localparam int N  = 4;
  localparam int AW = 64;
  localparam logic [AW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, vld_i = 1'b0;
  logic [1:0] op_i = '0, idx_i = '0;
  logic [AW-1:0] addr_i = '0, limit_i = '0;
  logic fault_o, ud_o;
  logic [1:0] fault_code_o, status_code_o;
  logic [AW-1:0] status_addr_o;

  always #4 clk = ~clk;

  ptr_bounds_unit dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .vld_i(vld_i), .op_i(op_i),
    .idx_i(idx_i), .addr_i(addr_i), .limit_i(limit_i), .fault_o(fault_o),
    .fault_code_o(fault_code_o), .ud_o(ud_o), .status_code_o(status_code_o),
    .status_addr_o(status_addr_o)
  );

  typedef struct {
    logic f; logic [1:0] fc; logic u; logic [1:0] sc; logic [AW-1:0] sa; string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] m_lo [N];
  logic [AW-1:0] m_hi [N];
  logic [1:0] m_sc;
  logic [AW-1:0] m_sa;
  logic done = 1'b0;

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: computes expected response from the requirements and queues it
  task automatic issue(input logic en, input logic [1:0] op, input int idx,
                       input logic [AW-1:0] a, input logic [AW-1:0] lim, input string tag);
    exp_t e;
    logic viol;
    @(negedge clk);
    en_i = en; vld_i = 1'b1; op_i = op; idx_i = 2'(idx); addr_i = a; limit_i = lim;
    e.f = 0; e.fc = 0; e.u = 0; e.tag = tag; viol = 0;
    if (!en) e.u = 1;
    else begin
      case (op)
        2'd0: begin m_lo[idx] = a; m_hi[idx] = lim; end
        2'd1: begin viol = a < m_lo[idx]; if (viol) begin e.f = 1; e.fc = 2'b11; end end
        2'd2: begin viol = a >= m_hi[idx]; if (viol) begin e.f = 1; e.fc = 2'b10; end end
        default: viol = a >= m_hi[idx];
      endcase
      if (viol) begin m_sc = 2'd1; m_sa = a; end
    end
    e.sc = m_sc; e.sa = m_sa;
    q.push_back(e);
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  // monitor: compares one cycle after each sampled request
  initial begin
    forever begin
      logic took;
      @(posedge clk);
      took = vld_i && rst_n;
      #2;
      if (took && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " fault"}, AW'(fault_o), AW'(e.f));
        chk({e.tag, " code"}, AW'(fault_code_o), AW'(e.fc));
        chk({e.tag, " ud"}, AW'(ud_o), AW'(e.u));
        chk({e.tag, " status code"}, AW'(status_code_o), AW'(e.sc));
        chk({e.tag, " status addr"}, status_addr_o, e.sa);
      end else if (rst_n) begin
        chk("R8 idle pulses", AW'({fault_o, ud_o}), '0);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = ONES; end
    m_sc = 0; m_sa = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status code", AW'(status_code_o), '0);
    chk("R1 reset status addr", status_addr_o, '0);
    chk("R8 reset pulses", AW'({fault_o, ud_o}), '0);

    for (int i = 0; i < N; i++) begin
      issue(1, 2'd1, i, '0, '0, "R1 lower at zero");
      issue(1, 2'd2, i, ONES - 1, '0, "R1 upper below ones");
    end
    issue(1, 2'd2, 3, ONES, '0, "R1 R4 all ones fails");

    for (int i = 0; i < N; i++)
      issue(1, 2'd0, i, 64'h1000 * (i + 1), 64'h1000 * (i + 1) + 64'h800, "R2 load");
    issue(1, 2'd1, 1, 64'h1FFF, '0, "R3 below lower");
    issue(1, 2'd1, 1, 64'h2000, '0, "R3 equal lower");
    issue(1, 2'd2, 1, 64'h27FF, '0, "R4 last inside");
    issue(1, 2'd2, 1, 64'h2800, '0, "R4 equal upper");
    issue(1, 2'd3, 2, 64'h3800, '0, "R5 soft violation");
    issue(1, 2'd3, 2, 64'h3400, '0, "R5 R6 soft pass keeps status");
    issue(1, 2'd1, 0, 64'h1000, '0, "R6 pass keeps status");
    issue(1, 2'd2, 0, 64'h1800, '0, "R2 other reg kept");
    issue(1, 2'd1, 3, 64'h0, '0, "R9 lower code");
    issue(1, 2'd2, 3, ONES, '0, "R9 upper code back to back");

    issue(0, 2'd0, 1, 64'h0, ONES, "R7 disabled load");
    issue(0, 2'd2, 1, ONES, '0, "R7 disabled check");
    issue(1, 2'd1, 1, 64'h1FFF, '0, "R7 bounds unchanged");
    issue(0, 2'd1, 0, 64'h5, '0, "R7 disabled keeps status");
    issue(1, 2'd0, 0, 64'h10, 64'h10, "R2 empty region");
    issue(1, 2'd2, 0, 64'h10, '0, "R4 empty region fails");
    issue(1, 2'd1, 0, 64'h10, '0, "R3 empty region lower ok");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule